// File: doc/BRIEF.md
# Shadow-Banked Data Register File

This block is the general-purpose data register file of one processing element. Sixteen architectural register names are backed by two physical banks of sixteen entries each, a primary bank and a secondary bank, for 32 storage words in all. Compute units and the two memory data buses reach the file through six read ports and four write ports, all usable in the same cycle.

A bank-select input, driven from a mode-control bit, chooses which bank every port addresses. Interrupt service code flips this bit to get a clean working set without saving or restoring anything. The change is registered, so it applies from the following cycle. Neither bank's contents are touched by a switch. Reads are combinational and show the state from before the coming clock edge. When several write ports name the same register in one cycle, the lowest-numbered port wins.

Top module: `regfile_banked`

## Requirements
- R1: While `rst_n` is low, all 32 entries clear to zero and the primary bank (bank select value 0) becomes active, so every read port returns zero.
- R2: Each read port `rd_data[r]` combinationally returns the entry named by `rd_addr[r]` in the active bank, independently of the other read ports.
- R3: A write port `p` with `wr_en[p]` high stores `wr_data[p]` into entry `wr_addr[p]` of the active bank at the rising clock edge.
- R4: A read of a register that is written in the same cycle returns the value from before that write; the new value is visible from the next cycle.
- R5: When two or more enabled write ports name the same register in one cycle, the value from the lowest-numbered of them is stored.
- R6: `bank_sel` value 0 selects the primary bank and value 1 the secondary bank; the value sampled at a clock edge governs reads and writes from that edge onward, so a write presented in the same cycle as a change of `bank_sel` still goes to the previously active bank.
- R7: Switching banks leaves the contents of both banks unchanged, and writes to one bank never alter the other bank.
- R8: A write port with `wr_en[p]` low changes no entry, whatever its address and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_sel | input | 1 | Mode bit: 0 primary bank, 1 secondary bank, registered |
| wr_en | input | NWR (4) | Per-port write enable |
| wr_addr | input | NWR x log2(N) (4x4) | Per-port write register number |
| wr_data | input | NWR x W (4x40) | Per-port write data |
| rd_addr | input | NRD x log2(N) (6x4) | Per-port read register number |
| rd_data | output | NRD x W (6x40) | Per-port combinational read data |

## Verification
The bench builds the file with its default parameters: 40-bit entries, 16 names per bank, six read ports and four write ports. These are the sizes the block is meant for, so every port and both banks get exercised. A phase that confines the write addresses to two registers makes three- and four-way write collisions common. This reaches the priority rule on every port pair, and random toggling of the bank bit lands bank changes in the same cycle as writes and reads.

// File: rtl/regfile_banked.sv
module regfile_banked #(
  parameter int W   = 40,
  parameter int N   = 16,
  parameter int NRD = 6,
  parameter int NWR = 4,
  localparam int AW = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bank_sel,
  input  logic [NWR-1:0]           wr_en,
  input  logic [NWR-1:0][AW-1:0]   wr_addr,
  input  logic [NWR-1:0][W-1:0]    wr_data,
  input  logic [NRD-1:0][AW-1:0]   rd_addr,
  output logic [NRD-1:0][W-1:0]    rd_data
);

  logic         bank_q;
  logic [W-1:0] mem [2][N];
  logic [N-1:0] hit;
  logic [W-1:0] wdat [N];

  for (genvar i = 0; i < N; i++) begin : g_sel
    always_comb begin
      hit[i]  = 1'b0;
      wdat[i] = '0;
      for (int p = NWR - 1; p >= 0; p--) begin
        if (wr_en[p] && wr_addr[p] == AW'(i)) begin
          hit[i]  = 1'b1;
          wdat[i] = wr_data[p];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < N; i++)
          mem[b][i] <= '0;
    end else begin
      bank_q <= bank_sel;
      for (int i = 0; i < N; i++)
        if (hit[i]) mem[bank_q][i] <= wdat[i];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = mem[bank_q][rd_addr[r]];
  end

endmodule

// File: rtl/regfile_banked_chk.sv
module regfile_banked_chk #(
  parameter int W   = 40,
  parameter int N   = 16,
  parameter int NRD = 6,
  parameter int NWR = 4,
  localparam int AW = $clog2(N)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bank_sel,
  input logic                   bank_q,
  input logic [NWR-1:0]         wr_en,
  input logic [NWR-1:0][AW-1:0] wr_addr,
  input logic [NWR-1:0][W-1:0]  wr_data,
  input logic [NRD-1:0][AW-1:0] rd_addr,
  input logic [NRD-1:0][W-1:0]  rd_data
);

  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |-> (rd_data == '0 && !bank_q));

  p_bank_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> bank_q == $past(bank_sel));

  p_port0_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wr_en[0]) && bank_q == $past(bank_q) && rd_addr[0] == $past(wr_addr[0]))
      |-> rd_data[0] == $past(wr_data[0]));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wr_en) == '0 && $stable(bank_q) && $stable(rd_addr[0]))
      |-> $stable(rd_data[0]));

  p_low_port_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(wr_en[1:0]) == 2'b11 && $past(wr_addr[0]) == $past(wr_addr[1])
      && bank_q == $past(bank_q) && rd_addr[1] == $past(wr_addr[1]))
      |-> rd_data[1] == $past(wr_data[0]));

endmodule

bind regfile_banked regfile_banked_chk #(.W(W), .N(N), .NRD(NRD), .NWR(NWR)) chk (.*);

// File: tb/regfile_banked_test.sv
module regfile_banked_test;
  localparam int W = 40, N = 16, NRD = 6, NWR = 4, AW = 4;

  logic clk = 0, rst_n = 0, bsel = 0;
  logic [NWR-1:0]         we = '0;
  logic [NWR-1:0][AW-1:0] wa = '0;
  logic [NWR-1:0][W-1:0]  wd = '0;
  logic [NRD-1:0][AW-1:0] ra = '0;
  logic [NRD-1:0][W-1:0]  rd;

  logic [W-1:0] m0 [N];
  logic [W-1:0] m1 [N];
  bit mb = 0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  regfile_banked uut (.clk(clk), .rst_n(rst_n), .bank_sel(bsel), .wr_en(we),
    .wr_addr(wa), .wr_data(wd), .rd_addr(ra), .rd_data(rd));

  function automatic logic [W-1:0] rnd40();
    return {8'($urandom), 32'($urandom)};
  endfunction

  task automatic check_reads(string tag);
    #1;
    for (int r = 0; r < NRD; r++) begin
      logic [W-1:0] exp;
      exp = mb ? m1[ra[r]] : m0[ra[r]];
      total++;
      if (rd !== rd) ;
      if (rd[r] !== exp) begin
        bad++;
        $display("FAIL %s port %0d addr %0d: got %h expected %h", tag, r, ra[r], rd[r], exp);
      end
    end
  endtask

  task automatic step(string tag);
    check_reads(tag);
    @(posedge clk);
    if (rst_n) begin
      for (int p = NWR - 1; p >= 0; p--)
        if (we[p]) begin
          if (mb) m1[wa[p]] = wd[p];
          else    m0[wa[p]] = wd[p];
        end
      mb = bsel;
    end
    @(negedge clk);
  endtask

  task automatic read_all(bit bank_now, string tag);
    we = '0;
    for (int base = 0; base < N; base += NRD) begin
      for (int r = 0; r < NRD; r++) ra[r] = AW'((base + r) % N);
      bsel = bank_now;
      step(tag);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m0[i] = '0; m1[i] = '0; end
    for (int i = 0; i < N; i++) begin
      for (int p = 0; p < NWR; p++) begin we[p] = 1; wa[p] = AW'(i); wd[p] = rnd40(); end
      for (int r = 0; r < NRD; r++) ra[r] = AW'((i + r) % N);
      bsel = i[0];
      @(negedge clk);
      check_reads("R1 in reset");
    end
    we = '0; bsel = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    read_all(0, "R1 primary after reset");
    read_all(1, "R1 secondary after reset");
    bsel = 0; we = '0; step("R6 back to primary");

    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < NWR; p++) begin we[p] = 1; wa[p] = AW'(k * NWR + p); wd[p] = rnd40(); end
      for (int r = 0; r < NRD; r++) ra[r] = AW'(k * NWR + (r % NWR));
      step("R4 read during write");
    end
    read_all(0, "R3 R2 distinct writes");

    for (int p = 0; p < NWR; p++) begin we[p] = 1; wa[p] = 4'd5; wd[p] = rnd40(); end
    step("R5 four-way collision");
    we = 4'b1100; wd[2] = rnd40(); wd[3] = rnd40(); wa[2] = 4'd5; wa[3] = 4'd5;
    step("R5 ports 2 and 3");
    we = '0; for (int r = 0; r < NRD; r++) ra[r] = 4'd5;
    step("R5 readback");

    we = '0;
    for (int p = 0; p < NWR; p++) begin wa[p] = AW'(p); wd[p] = rnd40(); end
    step("R8 disabled ports");
    read_all(0, "R8 contents kept");

    for (int p = 0; p < NWR; p++) begin we[p] = 1; wa[p] = AW'(p + 8); wd[p] = rnd40(); end
    bsel = 1;
    step("R6 write with bank change");
    for (int p = 0; p < NWR; p++) begin we[p] = 1; wa[p] = AW'(p + 8); wd[p] = rnd40(); end
    step("R6 secondary write");
    read_all(1, "R7 secondary view");
    read_all(0, "R7 primary intact");

    for (int c = 0; c < 3000; c++) begin
      for (int p = 0; p < NWR; p++) begin
        we[p] = 1'($urandom);
        wa[p] = (c < 1500) ? AW'($urandom % 2) : AW'($urandom);
        wd[p] = rnd40();
      end
      for (int r = 0; r < NRD; r++) ra[r] = (c < 1500) ? AW'($urandom % 2) : AW'($urandom);
      bsel = ($urandom % 5) == 0 ? ~bsel : bsel;
      step(c < 1500 ? "R5 random collisions" : "R2 random traffic");
    end
    read_all(0, "R7 final primary");
    read_all(1, "R7 final secondary");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule